// File: doc/BRIEF.md
# Issue Queue with Tag Wakeup

This block holds renamed instructions until their source operands are available, then sends them to execution out of program order. Each cycle up to `DISP_W` instructions arrive on the dispatch port. Every instruction carries two source physical tags, one destination physical tag and a sequence number. The sequence number gives the instruction's age. For each source operand, a ready flag from the rename stage says whether the register already holds its value. If it does not, the entry waits for that tag to appear on one of the `BC_W` broadcast ports.

A broadcast marks its producer as a single-cycle ALU operation or as a load. After an ALU broadcast, the woken consumer can issue in the very next cycle. After a load broadcast, the consumer needs one more cycle. Each cycle the queue grants up to `ISSUE_W` entries whose operands are all ready, oldest first, and frees them. Issue slot 0 carries the oldest. A flush removes every entry younger than a given sequence number. Dispatch is all or nothing: the ready output drops when the free entries cannot hold every requested lane.

Top module: `iq_tag_wakeup`

## Requirements
- R1: After reset no issue slot is valid, and a dispatch request of up to `DISP_W` lanes is accepted (`disp_ready_o` high).
- R2: An instruction dispatched with both source ready flags set issues in the cycle after dispatch, on slot 0 when it is the only candidate, and carries its own tags and sequence number.
- R3: An entry waiting on a tag stays unissued until that tag is broadcast with `bc_load_i` low in cycle t. If its other operand is ready, it issues in cycle t+1.
- R4: When the waited-on tag is broadcast with `bc_load_i` high in cycle t, the entry does not issue in cycle t+1 and does issue in cycle t+2.
- R5: A broadcast in the same cycle as dispatch also wakes the matching operand of the instruction being dispatched. After an ALU broadcast it issues in the next cycle; after a load broadcast it issues one cycle later.
- R6: When more than `ISSUE_W` entries are ready, the `ISSUE_W` oldest issue. Age is the modular order of sequence numbers: a is older than b when bit `SEQ_W-1` of a-b is set. Valid slots are packed from slot 0, and slot 0 holds the oldest. The rest issue in later cycles.
- R7: A ready younger entry issues while an older entry is still waiting for an operand.
- R8: While `flush_i` is high, entries whose sequence number is younger than `flush_seq_i` are removed and never issue. Entries that are equal or older stay. Dispatch is refused (`disp_ready_o` low) in that cycle.
- R9: `disp_ready_o` is low when fewer entries are free than the number of valid dispatch lanes. In that case no lane is written.
- R10: An entry issues once and its slot is then free for reuse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | DISP_W | Dispatch lane valid |
| disp_src1_i | input | DISP_W*TAG_W | First source tag per lane |
| disp_src2_i | input | DISP_W*TAG_W | Second source tag per lane |
| disp_dst_i | input | DISP_W*TAG_W | Destination tag per lane |
| disp_src_rdy_i | input | DISP_W*2 | Per lane: bit 0 first source ready, bit 1 second source ready |
| disp_seq_i | input | DISP_W*SEQ_W | Sequence number per lane |
| disp_ready_o | output | 1 | The current dispatch request is accepted |
| bc_valid_i | input | BC_W | Broadcast port valid |
| bc_tag_i | input | BC_W*TAG_W | Broadcast destination tag |
| bc_load_i | input | BC_W | Producer is a load (one extra cycle before consumers issue) |
| flush_i | input | 1 | Remove entries younger than flush_seq_i |
| flush_seq_i | input | SEQ_W | Flush boundary sequence number |
| issue_valid_o | output | ISSUE_W | Issue slot valid, packed from slot 0 |
| issue_src1_o | output | ISSUE_W*TAG_W | First source tag per slot |
| issue_src2_o | output | ISSUE_W*TAG_W | Second source tag per slot |
| issue_dst_o | output | ISSUE_W*TAG_W | Destination tag per slot |
| issue_seq_o | output | ISSUE_W*SEQ_W | Sequence number per slot |

## Verification
The age and slot-order properties assume three things about the inputs. Sequence numbers of instructions in flight are unique, and they span less than half the sequence space. The upstream stage offers new lanes only as the queue has room for them. The stimulus follows these rules: sequence numbers never repeat while in use, and one run crosses the wrap from 255 to 0 so that modular age is exercised. The backpressure property is checked only in cycles without a flush, and the stimulus keeps flushes apart from rejected dispatches. The load-delay property assumes a pending operand is never cleared by anything other than a flush. The stimulus never broadcasts a tag unless it is meant to wake a specific operand.

// File: rtl/iq_pkg.sv
package iq_pkg;
  parameter int unsigned TAG_W = 6;
  parameter int unsigned SEQ_W = 8;

  typedef struct packed {
    logic [SEQ_W-1:0] seq;
    logic [TAG_W-1:0] dst;
    logic [TAG_W-1:0] src2;
    logic [TAG_W-1:0] src1;
  } iq_uop_t;

  // a strictly older than b (modular sequence order)
  function automatic logic seq_older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction
endpackage

// File: rtl/iq_entry.sv
module iq_entry import iq_pkg::*; #(
  parameter int unsigned BC_W = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      alloc_i,
  input  iq_uop_t                   uop_i,
  input  logic [1:0]                src_rdy_i,
  input  logic [BC_W-1:0]           bc_valid_i,
  input  logic [BC_W-1:0][TAG_W-1:0] bc_tag_i,
  input  logic [BC_W-1:0]           bc_load_i,
  input  logic                      grant_i,
  input  logic                      flush_i,
  input  logic [SEQ_W-1:0]          flush_seq_i,
  output logic                      valid_o,
  output logic                      ready_o,
  output logic                      kill_o,
  output iq_uop_t                   uop_o
);
  logic           valid_q;
  iq_uop_t        uop_q;
  logic [1:0]     rdy_q, pend_q;
  logic [1:0]     alu_hit, ld_hit;
  logic [1:0][TAG_W-1:0] cmp_tag;
  logic [SEQ_W-1:0] age_diff;
  logic           kill;

  always_comb begin
    cmp_tag[0] = alloc_i ? uop_i.src1 : uop_q.src1;
    cmp_tag[1] = alloc_i ? uop_i.src2 : uop_q.src2;
    alu_hit = '0;
    ld_hit  = '0;
    for (int s = 0; s < 2; s++) begin
      for (int b = 0; b < int'(BC_W); b++) begin
        if (bc_valid_i[b] && bc_tag_i[b] == cmp_tag[s]) begin
          if (bc_load_i[b]) ld_hit[s] = 1'b1;
          else              alu_hit[s] = 1'b1;
        end
      end
    end
  end

  // younger than boundary: positive nonzero modular distance
  assign age_diff = uop_q.seq - flush_seq_i;
  assign kill     = valid_q && flush_i && !age_diff[SEQ_W-1] && (age_diff != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      uop_q   <= '0;
      rdy_q   <= '0;
      pend_q  <= '0;
    end else if (kill || grant_i) begin
      valid_q <= 1'b0;
      pend_q  <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      uop_q   <= uop_i;
      rdy_q   <= src_rdy_i | alu_hit;
      pend_q  <= ld_hit & ~(src_rdy_i | alu_hit);
    end else if (valid_q) begin
      // load wakeup lands one cycle after the broadcast
      rdy_q   <= rdy_q | pend_q | alu_hit;
      pend_q  <= ld_hit & ~(rdy_q | pend_q | alu_hit);
    end
  end

  assign valid_o = valid_q;
  assign ready_o = valid_q && (&rdy_q);
  assign kill_o  = kill;
  assign uop_o   = uop_q;

  for (genvar s = 0; s < 2; s++) begin : g_op_chk
    // R4
    pend_promote_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_q && pend_q[s] && !kill && !grant_i) |=> rdy_q[s]);
  end

  // R10
  grant_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> ready_o);

  // R10
  grant_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |=> !valid_q);

  // R8
  kill_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill |=> !valid_q);
endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
  parameter  int unsigned DEPTH  = 8,
  parameter  int unsigned DISP_W = 2,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned LANE_W = (DISP_W > 1) ? $clog2(DISP_W) : 1
) (
  input  logic [DEPTH-1:0]             free_i,
  input  logic [DISP_W-1:0]            req_i,
  input  logic                         block_i,
  output logic                         ok_o,
  output logic [DEPTH-1:0]             alloc_o,
  output logic [DEPTH-1:0][LANE_W-1:0] lane_o
);
  logic [CNT_W-1:0]              n_free, n_req;
  logic [DEPTH-1:0][CNT_W-1:0]   free_rank;
  logic [DISP_W-1:0][CNT_W-1:0]  lane_pos;

  always_comb begin
    n_free = '0;
    for (int e = 0; e < int'(DEPTH); e++) begin
      free_rank[e] = n_free;
      n_free = n_free + CNT_W'(free_i[e]);
    end
    n_req = '0;
    for (int d = 0; d < int'(DISP_W); d++) begin
      lane_pos[d] = n_req;
      n_req = n_req + CNT_W'(req_i[d]);
    end
    ok_o = !block_i && (n_free >= n_req);
    // k-th requesting lane goes to k-th free entry
    for (int e = 0; e < int'(DEPTH); e++) begin
      alloc_o[e] = 1'b0;
      lane_o[e]  = '0;
      for (int d = 0; d < int'(DISP_W); d++) begin
        if (ok_o && req_i[d] && free_i[e] && free_rank[e] == lane_pos[d]) begin
          alloc_o[e] = 1'b1;
          lane_o[e]  = LANE_W'(d);
        end
      end
    end
  end
endmodule

// File: rtl/iq_select.sv
module iq_select import iq_pkg::*; #(
  parameter  int unsigned DEPTH   = 8,
  parameter  int unsigned ISSUE_W = 4,
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0]   cand_i,
  input  iq_uop_t            uop_i   [DEPTH],
  output logic [DEPTH-1:0]   grant_o,
  output logic [ISSUE_W-1:0] iss_valid_o,
  output iq_uop_t            iss_uop_o [ISSUE_W]
);
  logic [DEPTH-1:0][CNT_W-1:0] rank;

  always_comb begin
    for (int e = 0; e < int'(DEPTH); e++) begin
      rank[e] = '0;
      for (int j = 0; j < int'(DEPTH); j++) begin
        if (cand_i[j] && j != e &&
            (seq_older(uop_i[j].seq, uop_i[e].seq) ||
             (uop_i[j].seq == uop_i[e].seq && j < e)))
          rank[e] = rank[e] + 1'b1;
      end
      grant_o[e] = cand_i[e] && (rank[e] < CNT_W'(ISSUE_W));
    end
    for (int k = 0; k < int'(ISSUE_W); k++) begin
      iss_valid_o[k] = 1'b0;
      iss_uop_o[k]   = '0;
      for (int e = 0; e < int'(DEPTH); e++) begin
        if (grant_o[e] && rank[e] == CNT_W'(k)) begin
          iss_valid_o[k] = 1'b1;
          iss_uop_o[k]   = iss_uop_o[k] | uop_i[e];
        end
      end
    end
  end
endmodule

// File: rtl/iq_tag_wakeup.sv
module iq_tag_wakeup import iq_pkg::*; #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned DISP_W  = 2,
  parameter int unsigned ISSUE_W = 4,
  parameter int unsigned BC_W    = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [DISP_W-1:0]             disp_valid_i,
  input  logic [DISP_W-1:0][TAG_W-1:0]  disp_src1_i,
  input  logic [DISP_W-1:0][TAG_W-1:0]  disp_src2_i,
  input  logic [DISP_W-1:0][TAG_W-1:0]  disp_dst_i,
  input  logic [DISP_W-1:0][1:0]        disp_src_rdy_i,
  input  logic [DISP_W-1:0][SEQ_W-1:0]  disp_seq_i,
  output logic                          disp_ready_o,
  input  logic [BC_W-1:0]               bc_valid_i,
  input  logic [BC_W-1:0][TAG_W-1:0]    bc_tag_i,
  input  logic [BC_W-1:0]               bc_load_i,
  input  logic                          flush_i,
  input  logic [SEQ_W-1:0]              flush_seq_i,
  output logic [ISSUE_W-1:0]            issue_valid_o,
  output logic [ISSUE_W-1:0][TAG_W-1:0] issue_src1_o,
  output logic [ISSUE_W-1:0][TAG_W-1:0] issue_src2_o,
  output logic [ISSUE_W-1:0][TAG_W-1:0] issue_dst_o,
  output logic [ISSUE_W-1:0][SEQ_W-1:0] issue_seq_o
);
  localparam int unsigned LANE_W = (DISP_W > 1) ? $clog2(DISP_W) : 1;

  logic [DEPTH-1:0]             ent_valid, ent_ready, ent_kill, ent_alloc, cand, grant;
  logic [DEPTH-1:0][LANE_W-1:0] ent_lane;
  iq_uop_t                      ent_uop [DEPTH];
  iq_uop_t                      disp_uop [DISP_W];
  iq_uop_t                      iss_uop [ISSUE_W];

  always_comb begin
    for (int d = 0; d < int'(DISP_W); d++) begin
      disp_uop[d].seq  = disp_seq_i[d];
      disp_uop[d].dst  = disp_dst_i[d];
      disp_uop[d].src2 = disp_src2_i[d];
      disp_uop[d].src1 = disp_src1_i[d];
    end
  end

  iq_alloc #(.DEPTH(DEPTH), .DISP_W(DISP_W)) u_alloc (
    .free_i  (~ent_valid),
    .req_i   (disp_valid_i),
    .block_i (flush_i),
    .ok_o    (disp_ready_o),
    .alloc_o (ent_alloc),
    .lane_o  (ent_lane)
  );

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    iq_entry #(.BC_W(BC_W)) u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (ent_alloc[e]),
      .uop_i       (disp_uop[ent_lane[e]]),
      .src_rdy_i   (disp_src_rdy_i[ent_lane[e]]),
      .bc_valid_i  (bc_valid_i),
      .bc_tag_i    (bc_tag_i),
      .bc_load_i   (bc_load_i),
      .grant_i     (grant[e]),
      .flush_i     (flush_i),
      .flush_seq_i (flush_seq_i),
      .valid_o     (ent_valid[e]),
      .ready_o     (ent_ready[e]),
      .kill_o      (ent_kill[e]),
      .uop_o       (ent_uop[e])
    );
  end

  assign cand = ent_ready & ~ent_kill;

  iq_select #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) u_sel (
    .cand_i      (cand),
    .uop_i       (ent_uop),
    .grant_o     (grant),
    .iss_valid_o (issue_valid_o),
    .iss_uop_o   (iss_uop)
  );

  always_comb begin
    for (int k = 0; k < int'(ISSUE_W); k++) begin
      issue_src1_o[k] = iss_uop[k].src1;
      issue_src2_o[k] = iss_uop[k].src2;
      issue_dst_o[k]  = iss_uop[k].dst;
      issue_seq_o[k]  = iss_uop[k].seq;
    end
  end

  for (genvar k = 1; k < ISSUE_W; k++) begin : g_slot_chk
    // R6
    issue_pack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_valid_o[k] |-> issue_valid_o[k-1]);
    // R6
    issue_age_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_valid_o[k] |-> seq_older(issue_seq_o[k-1], issue_seq_o[k]));
  end

  // R9
  disp_bp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !disp_ready_o) |=>
      ($countones(ent_valid) == $past($countones(ent_valid)) - $past($countones(grant))));
endmodule

// File: tb/iq_tag_wakeup_test.sv
module iq_tag_wakeup_test;
  localparam int TW = 6;
  localparam int SW = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0]         disp_valid_i;
  logic [1:0][TW-1:0] disp_src1_i, disp_src2_i, disp_dst_i;
  logic [1:0][1:0]    disp_src_rdy_i;
  logic [1:0][SW-1:0] disp_seq_i;
  logic               disp_ready_o;
  logic [1:0]         bc_valid_i;
  logic [1:0][TW-1:0] bc_tag_i;
  logic [1:0]         bc_load_i;
  logic               flush_i;
  logic [SW-1:0]      flush_seq_i;
  logic [3:0]         issue_valid_o;
  logic [3:0][TW-1:0] issue_src1_o, issue_src2_o, issue_dst_o;
  logic [3:0][SW-1:0] issue_seq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  iq_tag_wakeup uut (.*);

  always #5 clk_i = ~clk_i;

  task automatic clear_in();
    disp_valid_i = '0; disp_src1_i = '0; disp_src2_i = '0; disp_dst_i = '0;
    disp_src_rdy_i = '0; disp_seq_i = '0;
    bc_valid_i = '0; bc_tag_i = '0; bc_load_i = '0;
    flush_i = 1'b0; flush_seq_i = '0;
  endtask

  task automatic lane(input int l, input int seq, input int s1, input bit r1,
                      input int s2, input bit r2, input int dst);
    disp_valid_i[l] = 1'b1;
    disp_seq_i[l] = SW'(seq);
    disp_src1_i[l] = TW'(s1);
    disp_src2_i[l] = TW'(s2);
    disp_dst_i[l] = TW'(dst);
    disp_src_rdy_i[l] = {r2, r1};
  endtask

  task automatic bcast(input int p, input int tag, input bit ld);
    bc_valid_i[p] = 1'b1;
    bc_tag_i[p] = TW'(tag);
    bc_load_i[p] = ld;
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
    clear_in();
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_issue(input string req, input int n,
                           input int q0, input int q1, input int q2, input int q3);
    int exp_seq[4];
    exp_seq = '{q0, q1, q2, q3};
    #1;
    chk(req, "issue_valid", int'(issue_valid_o), (1 << n) - 1);
    for (int k = 0; k < n; k++) chk(req, "issue_seq", int'(issue_seq_o[k]), exp_seq[k]);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    clear_in();
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "issue_valid", int'(issue_valid_o), 0);
    lane(0, 100, 1, 1, 1, 1, 1); lane(1, 101, 1, 1, 1, 1, 1);
    #1 chk("R1", "disp_ready", int'(disp_ready_o), 1);
    clear_in();
    @(negedge clk_i);

    // R2 ready at dispatch
    lane(0, 1, 1, 1, 2, 1, 10);
    tick();
    chk_issue("R2", 1, 1, 0, 0, 0);
    chk("R2", "dst", int'(issue_dst_o[0]), 10);
    chk("R2", "src1", int'(issue_src1_o[0]), 1);
    chk("R2", "src2", int'(issue_src2_o[0]), 2);
    tick();
    chk_issue("R10", 0, 0, 0, 0, 0);

    // R3 ALU wakeup, back to back
    lane(0, 2, 20, 0, 3, 1, 11);
    tick();
    chk_issue("R3", 0, 0, 0, 0, 0);
    bcast(0, 20, 0);
    tick();
    chk_issue("R3", 1, 2, 0, 0, 0);
    tick();
    chk_issue("R10", 0, 0, 0, 0, 0);

    // R4 load wakeup, one extra cycle
    lane(0, 3, 21, 0, 4, 1, 12);
    tick();
    chk_issue("R4", 0, 0, 0, 0, 0);
    bcast(1, 21, 1);
    tick();
    chk_issue("R4", 0, 0, 0, 0, 0);
    tick();
    chk_issue("R4", 1, 3, 0, 0, 0);
    tick();

    // R5 broadcast during dispatch
    lane(0, 4, 22, 0, 5, 1, 13);
    bcast(0, 22, 0);
    tick();
    chk_issue("R5", 1, 4, 0, 0, 0);
    tick();
    chk_issue("R5", 0, 0, 0, 0, 0);
    lane(0, 5, 23, 1, 24, 0, 14);
    bcast(1, 24, 1);
    tick();
    chk_issue("R5", 0, 0, 0, 0, 0);
    tick();
    chk_issue("R5", 1, 5, 0, 0, 0);
    tick();

    // R7 younger ready passes older waiting
    lane(0, 6, 30, 0, 1, 1, 15);
    lane(1, 7, 2, 1, 3, 1, 16);
    tick();
    chk_issue("R7", 1, 7, 0, 0, 0);
    tick();
    chk_issue("R7", 0, 0, 0, 0, 0);
    bcast(0, 30, 0);
    tick();
    chk_issue("R7", 1, 6, 0, 0, 0);
    tick();

    // R6 oldest four of six, scrambled dispatch order
    begin
      int sq[6];
      sq = '{15, 11, 13, 10, 14, 12};
      for (int c = 0; c < 3; c++) begin
        lane(0, sq[2*c], 40, 0, 1, 1, 20 + 2*c);
        lane(1, sq[2*c+1], 40, 0, 1, 1, 21 + 2*c);
        tick();
        chk_issue("R6", 0, 0, 0, 0, 0);
      end
    end
    bcast(0, 40, 0);
    tick();
    chk_issue("R6", 4, 10, 11, 12, 13);
    tick();
    chk_issue("R6", 2, 14, 15, 0, 0);
    tick();
    chk_issue("R6", 0, 0, 0, 0, 0);

    // R9 backpressure, sequence numbers crossing the wrap
    for (int c = 0; c < 3; c++) begin
      lane(0, 250 + 2*c, 50, 0, 1, 1, 30);
      lane(1, 251 + 2*c, 50, 0, 1, 1, 31);
      #1 chk("R9", "disp_ready", int'(disp_ready_o), 1);
      tick();
    end
    lane(0, 0, 50, 0, 1, 1, 32);
    tick();
    lane(0, 248, 1, 1, 1, 1, 33);
    lane(1, 249, 1, 1, 1, 1, 34);
    #1 chk("R9", "disp_ready", int'(disp_ready_o), 0);
    tick();
    chk_issue("R9", 0, 0, 0, 0, 0);
    lane(1, 1, 50, 0, 1, 1, 35);
    #1 chk("R9", "disp_ready", int'(disp_ready_o), 1);
    tick();
    lane(0, 249, 1, 1, 1, 1, 36);
    #1 chk("R9", "disp_ready", int'(disp_ready_o), 0);
    tick();
    chk_issue("R9", 0, 0, 0, 0, 0);

    // R8 flush younger than 253
    flush_i = 1'b1;
    flush_seq_i = 8'd253;
    lane(0, 248, 1, 1, 1, 1, 37);
    #1 chk("R8", "disp_ready", int'(disp_ready_o), 0);
    tick();
    chk_issue("R8", 0, 0, 0, 0, 0);
    bcast(0, 50, 0);
    tick();
    chk_issue("R8", 4, 250, 251, 252, 253);
    tick();
    chk_issue("R8", 0, 0, 0, 0, 0);
    lane(0, 60, 1, 1, 1, 1, 1); lane(1, 61, 1, 1, 1, 1, 1);
    #1 chk("R10", "disp_ready", int'(disp_ready_o), 1);
    clear_in();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule